// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block is the arithmetic unit of a small processor core. Each cycle it may accept one operation on two operands: addition, subtraction, bitwise AND, increment, decrement or move. A width input picks whether the operation works on the low byte or on the full 16-bit word. The result is registered and appears on the output one clock after the operation is issued.

Alongside the result, the block keeps a 16-bit flag register. Six status bits describe each result: carry or borrow, even parity of the low byte, carry or borrow out of the low nibble for decimal correction, zero, sign and signed overflow. The register also holds three control bits (single step, interrupt enable, string direction). Arithmetic never alters these control bits. A separate write port loads the whole register at once, for example when a saved flag word is restored.

Increment and decrement are meant for counting loops, so they refresh every status bit except carry. A move only copies an operand and touches no flag.

Top module: `alu_flags_core`

## Requirements
- R1: An accepted operation (op_valid=1) with op_sel 0=add, 1=sub (a-b), 2=AND, 3=increment a, 4=decrement a, 5=move b places its result on `result` after the next rising clock edge. With word_mode=0 only bits 7:0 are computed and bits 15:8 of `result` read 0.
- R2: Flag bit positions are carry 0, parity 2, nibble carry 4, zero 6, sign 7, single step 8, interrupt enable 9, direction 10, overflow 11. All other flag bits always read 0, even after a write of ones.
- R3: For add, bit 0 is the carry out of the selected width; for subtract it is set when the unsigned a is smaller than b (borrow).
- R4: For add, sub, AND, increment and decrement, bit 2 is set when bits 7:0 of the result hold an even number of ones, in either width.
- R5: For add and increment, bit 4 is the carry out of bit 3; for sub and decrement, it is the borrow into bit 4 (a[3:0] < b[3:0]).
- R6: Bit 6 is set when the result within the selected width is zero, and bit 7 copies its top bit (7 or 15).
- R7: Bit 11 is set on two's-complement overflow of the selected width for add, sub, increment and decrement.
- R8: Increment and decrement keep bit 0 at its previous value while updating every other status bit.
- R9: AND clears bits 0, 4 and 11.
- R10: Move changes no flag. Codes 6 and 7, and cycles with op_valid=0, change neither the result nor the flags.
- R11: flag_we=1 loads flag_wdata into all nine defined flag bits after the next edge and overrides any flag update from an operation in the same cycle. Operations never change bits 8 to 10.
- R12: After reset, `result` and `flags` are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Issue an operation this cycle |
| op_sel | input | 3 | Operation code |
| word_mode | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| flag_we | input | 1 | Load the flag register from flag_wdata |
| flag_wdata | input | 16 | Value to load into the flag register |
| result | output | 16 | Registered result |
| flags | output | 16 | Flag register |

## Verification
On every cycle the assertions check the invariants: reserved bits stay zero, arithmetic leaves the control bits alone, increment and decrement hold carry, AND clears its three bits, move and idle cycles keep state, and zero, parity and byte-mode truncation agree with the registered result. Whether the carry, nibble carry and overflow values are correct for given operands can only be shown by the bench's scenarios. It compares every flag field against an arithmetic model on random operands and on directed wrap-around cases at the byte and word boundaries.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_INC  = 3'd3,
        OP_DEC  = 3'd4,
        OP_MOV  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } alu_op_e;

    localparam int FLAG_W = 16;

    localparam int FB_CY  = 0;
    localparam int FB_PAR = 2;
    localparam int FB_NIB = 4;
    localparam int FB_ZER = 6;
    localparam int FB_NEG = 7;
    localparam int FB_STP = 8;
    localparam int FB_IEN = 9;
    localparam int FB_DIR = 10;
    localparam int FB_OVF = 11;

    localparam logic [FLAG_W-1:0] FLAG_LIVE_MASK =
        (16'd1 << FB_CY)  | (16'd1 << FB_PAR) | (16'd1 << FB_NIB) |
        (16'd1 << FB_ZER) | (16'd1 << FB_NEG) | (16'd1 << FB_STP) |
        (16'd1 << FB_IEN) | (16'd1 << FB_DIR) | (16'd1 << FB_OVF);

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              c_nib,
    output logic              c_byte,
    output logic              c_top,
    output logic              v_byte,
    output logic              v_top
);
    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   full;
    logic [DATA_W-1:0] cin_vec;

    always_comb begin
        b_eff   = sub ? ~b : b;
        full    = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
        sum     = full[DATA_W-1:0];
        cin_vec = a ^ b_eff ^ sum;
        c_nib   = cin_vec[NIB_W];
        c_byte  = cin_vec[BYTE_W];
        c_top   = full[DATA_W];
        v_byte  = cin_vec[BYTE_W-1] ^ cin_vec[BYTE_W];
        v_top   = cin_vec[DATA_W-1] ^ full[DATA_W];
    end

endmodule

// File: rtl/alu_status.sv
module alu_status
    import alu_flags_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_e           op,
    input  logic              word,
    input  logic [DATA_W-1:0] res,
    input  logic              c_nib,
    input  logic              c_byte,
    input  logic              c_top,
    input  logic              v_byte,
    input  logic              v_top,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [FLAG_W-1:0] flags_out
);
    localparam int BYTE_W = 8;

    logic is_borrow;
    logic cy, nib, ovf, neg, zer, par;

    always_comb begin
        is_borrow = (op == OP_SUB) || (op == OP_DEC);
        cy  = (word ? c_top : c_byte) ^ is_borrow;
        nib = c_nib ^ is_borrow;
        ovf = word ? v_top : v_byte;
        neg = word ? res[DATA_W-1] : res[BYTE_W-1];
        zer = word ? (res == '0) : (res[BYTE_W-1:0] == '0);
        par = ~^res[BYTE_W-1:0];

        flags_out = flags_in;
        case (op)
            OP_ADD, OP_SUB, OP_INC, OP_DEC: begin
                if (!((op == OP_INC) || (op == OP_DEC))) begin
                    flags_out[FB_CY] = cy;
                end
                flags_out[FB_NIB] = nib;
                flags_out[FB_OVF] = ovf;
                flags_out[FB_NEG] = neg;
                flags_out[FB_ZER] = zer;
                flags_out[FB_PAR] = par;
            end
            OP_AND: begin
                flags_out[FB_CY]  = 1'b0;
                flags_out[FB_NIB] = 1'b0;
                flags_out[FB_OVF] = 1'b0;
                flags_out[FB_NEG] = neg;
                flags_out[FB_ZER] = zer;
                flags_out[FB_PAR] = par;
            end
            default: flags_out = flags_in;
        endcase
    end

endmodule

// File: rtl/alu_flags_core.sv
module alu_flags_core
    import alu_flags_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_sel,
    input  logic              word_mode,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              flag_we,
    input  logic [FLAG_W-1:0] flag_wdata,
    output logic [DATA_W-1:0] result,
    output logic [FLAG_W-1:0] flags
);
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic [FLAG_W-1:0] flg;
    } core_state_t;

    core_state_t state_d, state_q;

    alu_op_e           op;
    logic              op_known;
    logic [DATA_W-1:0] add_b;
    logic              add_sub;
    logic [DATA_W-1:0] add_sum;
    logic              c_nib, c_byte, c_top, v_byte, v_top;
    logic [DATA_W-1:0] raw_res;
    logic [DATA_W-1:0] fit_res;
    logic [FLAG_W-1:0] stat_flags;

    assign op       = alu_op_e'(op_sel);
    assign op_known = (op_sel <= 3'(OP_MOV));

    always_comb begin
        add_b   = opnd_b;
        add_sub = 1'b0;
        case (op)
            OP_SUB: add_sub = 1'b1;
            OP_INC: add_b   = {{(DATA_W-1){1'b0}}, 1'b1};
            OP_DEC: begin
                add_b   = {{(DATA_W-1){1'b0}}, 1'b1};
                add_sub = 1'b1;
            end
            default: ;
        endcase
    end

    alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a      (opnd_a),
        .b      (add_b),
        .sub    (add_sub),
        .sum    (add_sum),
        .c_nib  (c_nib),
        .c_byte (c_byte),
        .c_top  (c_top),
        .v_byte (v_byte),
        .v_top  (v_top)
    );

    always_comb begin
        case (op)
            OP_AND:  raw_res = opnd_a & opnd_b;
            OP_MOV:  raw_res = opnd_b;
            default: raw_res = add_sum;
        endcase
        fit_res = word_mode ? raw_res
                            : {{(DATA_W-BYTE_W){1'b0}}, raw_res[BYTE_W-1:0]};
    end

    alu_status #(.DATA_W(DATA_W)) u_status (
        .op        (op),
        .word      (word_mode),
        .res       (fit_res),
        .c_nib     (c_nib),
        .c_byte    (c_byte),
        .c_top     (c_top),
        .v_byte    (v_byte),
        .v_top     (v_top),
        .flags_in  (state_q.flg),
        .flags_out (stat_flags)
    );

    always_comb begin
        state_d = state_q;
        if (op_valid && op_known) begin
            state_d.res = fit_res;
            state_d.flg = stat_flags;
        end
        if (flag_we) begin
            state_d.flg = flag_wdata & FLAG_LIVE_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result = state_q.res;
    assign flags  = state_q.flg;

endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk
    import alu_flags_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [2:0]  op_sel,
    input logic        word_mode,
    input logic        flag_we,
    input logic [15:0] result,
    input logic [15:0] flags
);
    logic arith_op;
    logic updates_status;
    assign arith_op       = op_valid && !flag_we &&
                            (op_sel == 3'(OP_ADD) || op_sel == 3'(OP_SUB) ||
                             op_sel == 3'(OP_INC) || op_sel == 3'(OP_DEC));
    assign updates_status = arith_op ||
                            (op_valid && !flag_we && op_sel == 3'(OP_AND));

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & ~FLAG_LIVE_MASK) == 16'h0);

    // R11
    ctrl_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> flags[FB_DIR:FB_STP] == $past(flags[FB_DIR:FB_STP]));

    // R8
    incdec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !flag_we && (op_sel == 3'(OP_INC) || op_sel == 3'(OP_DEC)))
        |=> flags[FB_CY] == $past(flags[FB_CY]));

    // R9
    and_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !flag_we && op_sel == 3'(OP_AND))
        |=> !flags[FB_CY] && !flags[FB_NIB] && !flags[FB_OVF]);

    // R10
    mov_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !flag_we && op_sel == 3'(OP_MOV)) |=> $stable(flags));

    // R10
    idle_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_we && (!op_valid || op_sel > 3'(OP_MOV)))
        |=> $stable(flags) && $stable(result));

    // R6
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        updates_status |=> flags[FB_ZER] ==
            ($past(word_mode) ? (result == 16'h0) : (result[7:0] == 8'h0)));

    // R4
    parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        updates_status |=> flags[FB_PAR] == ~^result[7:0]);

    // R1
    byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel <= 3'(OP_MOV) && !word_mode) |=> result[15:8] == 8'h0);

endmodule

bind alu_flags_core alu_flags_chk u_flags_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_sel    (op_sel),
    .word_mode (word_mode),
    .flag_we   (flag_we),
    .result    (result),
    .flags     (flags)
);

// File: tb/alu_flags_core_test.sv
`timescale 1ns/1ps
module alu_flags_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_sel = 3'd0;
    logic        word_mode = 1'b0;
    logic [15:0] opnd_a = 16'h0;
    logic [15:0] opnd_b = 16'h0;
    logic        flag_we = 1'b0;
    logic [15:0] flag_wdata = 16'h0;
    logic [15:0] result;
    logic [15:0] flags;

    int n_checks = 0;
    int n_errors = 0;
    logic [15:0] exp_res = 16'h0;
    logic [15:0] exp_flg = 16'h0;

    always #2 clk = ~clk;

    alu_flags_core uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .word_mode(word_mode), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .flag_we(flag_we), .flag_wdata(flag_wdata),
        .result(result), .flags(flags)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected {result, flags} from the requirements.
    function automatic logic [31:0] model(input logic [2:0] op, input logic w,
        input logic [15:0] a, input logic [15:0] b, input logic v,
        input logic fwe, input logic [15:0] fdat,
        input logic [15:0] pres, input logic [15:0] pflg);
        int unsigned m, ua, ub, na, nb, full;
        int          tb;
        logic [15:0] r, f;
        logic sa, sb, sr, is_sub;
        r = pres; f = pflg;
        m = w ? 32'hFFFF : 32'hFF;
        tb = w ? 15 : 7;
        ua = a & m; ub = b & m;
        if (v && op <= 3'd5) begin
            if (op == 3'd3 || op == 3'd4) ub = 1;
            is_sub = (op == 3'd1 || op == 3'd4);
            na = ua & 15; nb = ub & 15;
            if (op == 3'd2) full = ua & ub;
            else if (op == 3'd5) full = ub;
            else if (is_sub) full = (ua - ub) & m;
            else full = ua + ub;
            r = 16'(full & m);
            if (op <= 3'd4) begin
                f[6] = (r == 0);
                f[7] = r[tb];
                f[2] = ~^r[7:0];
            end
            if (op == 3'd2) begin
                f[0] = 0; f[4] = 0; f[11] = 0;
            end else if (op != 3'd5) begin
                sa = ua[tb]; sb = ub[tb]; sr = r[tb];
                if (is_sub) begin
                    f[4]  = na < nb;
                    f[11] = (sa != sb) && (sr != sa);
                    if (op == 3'd1) f[0] = ua < ub;
                end else begin
                    f[4]  = (na + nb) > 15;
                    f[11] = (sa == sb) && (sr != sa);
                    if (op == 3'd0) f[0] = full > m;
                end
            end
        end
        if (fwe) f = fdat & 16'h0FD5;
        return {r, f};
    endfunction

    task automatic step(input logic v, input logic [2:0] op, input logic w,
                        input logic [15:0] a, input logic [15:0] b,
                        input logic fwe, input logic [15:0] fdat);
        logic [31:0] e;
        string tc, ta;
        @(negedge clk);
        op_valid = v; op_sel = op; word_mode = w; opnd_a = a; opnd_b = b;
        flag_we = fwe; flag_wdata = fdat;
        e = model(op, w, a, b, v, fwe, fdat, exp_res, exp_flg);
        exp_res = e[31:16]; exp_flg = e[15:0];
        @(posedge clk);
        #1;
        op_valid = 1'b0; flag_we = 1'b0;
        tc = (op == 3'd3 || op == 3'd4) ? "R8 carry hold" :
             (op == 3'd2) ? "R9 carry" : (op >= 3'd5) ? "R10 carry" : "R3 carry";
        ta = (op == 3'd2) ? "R9 nibble" : "R5 nibble";
        chk((v && op > 3'd4) ? "R10 result" : "R1 result", result, exp_res);
        chk(fwe ? "R11 write" : tc, {15'h0, flags[0]}, {15'h0, exp_flg[0]});
        chk("R4 parity", {15'h0, flags[2]}, {15'h0, exp_flg[2]});
        chk(ta, {15'h0, flags[4]}, {15'h0, exp_flg[4]});
        chk("R6 zero/sign", {14'h0, flags[7:6]}, {14'h0, exp_flg[7:6]});
        chk(op == 3'd2 ? "R9 overflow" : "R7 overflow", {15'h0, flags[11]}, {15'h0, exp_flg[11]});
        chk("R11 control", {13'h0, flags[10:8]}, {13'h0, exp_flg[10:8]});
        chk("R2 reserved", flags & 16'hF02A, 16'h0);
    endtask

    initial begin
        #(200000 * 4);
        n_errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd7741));
        repeat (3) @(posedge clk);
        #1;
        chk("R12 reset result", result, 16'h0);
        chk("R12 reset flags", flags, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: writing ones sets only defined bits
        step(0, 3'd0, 1, 16'h0, 16'h0, 1, 16'hFFFF);
        chk("R2 live mask", flags, 16'h0FD5);
        // R11: op in same cycle as write, write wins for flags
        step(1, 3'd0, 1, 16'hFFFF, 16'h0001, 1, 16'h0700);
        // R1 R3 R5 R6 R4: byte wrap 0xFF+1
        step(1, 3'd0, 0, 16'h12FF, 16'h0001, 0, 16'h0);
        // R7: word signed overflow
        step(1, 3'd0, 1, 16'h7FFF, 16'h0001, 0, 16'h0);
        // R3: borrow 0-1
        step(1, 3'd1, 1, 16'h0000, 16'h0001, 0, 16'h0);
        // R8: increment of 0xFFFF keeps carry set from previous borrow
        step(1, 3'd3, 1, 16'hFFFF, 16'h0, 0, 16'h0);
        // R7 R8: decrement of 0x8000
        step(1, 3'd4, 1, 16'h8000, 16'h0, 0, 16'h0);
        // R7: byte decrement of 0x80
        step(1, 3'd4, 0, 16'h0080, 16'h0, 0, 16'h0);
        // R9: AND after carry set
        step(1, 3'd1, 0, 16'h0001, 16'h0002, 0, 16'h0);
        step(1, 3'd2, 1, 16'hF0F0, 16'h8F0F, 0, 16'h0);
        // R10: move, undefined codes, idle
        step(1, 3'd5, 1, 16'h0, 16'hA5A5, 0, 16'h0);
        step(1, 3'd6, 1, 16'h1234, 16'h5678, 0, 16'h0);
        step(1, 3'd7, 0, 16'h1234, 16'h5678, 0, 16'h0);
        step(0, 3'd0, 1, 16'h1234, 16'h5678, 0, 16'h0);

        for (int i = 0; i < 3000; i++) begin
            logic [2:0] op;
            logic       fw;
            op = 3'($urandom_range(0, 7));
            fw = ($urandom_range(0, 15) == 0);
            step($urandom_range(0, 7) != 0, op, 1'($urandom),
                 16'($urandom), 16'($urandom), fw, 16'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule